// File: doc/BRIEF.md
# Multi-Mode Block RAM

This block is an on-chip memory of 512 words by 9 bits (4608 bits). A 2-bit configuration input picks its personality. As a single-port RAM, one address serves both reads and writes. As a dual-port RAM, one port writes while the other reads independently. As a FIFO, push and pop requests move words through the same storage, and the block reports its fill level, full and empty status, and sticky overflow and underflow flags.

The ninth bit of each word can be ordinary data, or it can be a parity bit. When parity is on, the block computes the bit as it writes the word. It checks the bit on every read and raises a one-cycle error pulse alongside the returned word when the bit does not match. All reads are registered, so data arrives one clock after the request. Changing the configured personality clears the FIFO bookkeeping. The stored words are left untouched.

Top module: `mram_top`

## Requirements
- R1: While reset is held and right after it, rd_valid and par_err are 0, q_empty is 1, and q_full, q_ovf, q_udf and q_level are all 0.
- R2: With cfg_mode = 0 (single port), a cycle with p0_en=1 and p0_we=1 writes the word at p0_addr. A cycle with p0_en=1 and p0_we=0 reads p0_addr. A cycle with p0_en=0 changes nothing.
- R3: With cfg_mode = 1 (dual port), p0_en=1 with p0_we=1 writes at p0_addr, and p1_en=1 reads p1_addr in the same cycle. When both target the same address, the read returns the word held before the write.
- R4: A read accepted at clock edge k puts its word on rd_data with rd_valid=1 after edge k+1. rd_valid is 0 after every edge that accepted no read.
- R5: When cfg_par_en=1 during a write, the block stores bit 8 as the XOR of bits 7:0 (even parity over 9 bits). The bit 8 supplied by the writer is discarded.
- R6: When cfg_par_en=0 during a write, all 9 supplied bits are stored unchanged.
- R7: When cfg_par_en=1 at the cycle a read is accepted, par_err is 1 together with rd_valid exactly when the stored bit 8 differs from the XOR of stored bits 7:0. Otherwise par_err is 0.
- R8: With cfg_mode = 2 (FIFO), q_push writes p0_wdata and q_pop reads, in first-in first-out order. q_level counts the stored words, q_empty is 1 at level 0, and q_full is 1 at level 512. After a clear, pushes fill addresses 0, 1, 2 and onward of the shared storage.
- R9: In FIFO mode, a push while full and a pop while empty change neither the storage nor q_level. They set q_ovf or q_udf respectively, and that flag stays at 1 until the next mode change.
- R10: A cycle in which cfg_mode differs from its value at the previous clock clears q_level, q_ovf and q_udf and sets q_empty. Any push or pop presented in that cycle is ignored.
- R11: Ports unused by the selected mode have no effect: FIFO mode ignores p0/p1 accesses, single and dual port modes ignore q_push/q_pop, and cfg_mode = 3 performs no access at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Personality: 0 single port, 1 dual port, 2 FIFO, 3 idle |
| cfg_par_en | input | 1 | Generate parity on write and check on read |
| p0_en | input | 1 | Port 0 access enable |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | 9 | Port 0 address |
| p0_wdata | input | 9 | Write word for port 0 and FIFO push |
| p1_en | input | 1 | Port 1 read enable (dual port) |
| p1_addr | input | 9 | Port 1 read address |
| q_push | input | 1 | FIFO push request |
| q_pop | input | 1 | FIFO pop request |
| rd_data | output | 9 | Registered read word |
| rd_valid | output | 1 | rd_data holds a fresh word |
| par_err | output | 1 | Parity mismatch on the word in rd_data |
| q_full | output | 1 | FIFO holds 512 words |
| q_empty | output | 1 | FIFO holds no word |
| q_level | output | 10 | FIFO word count |
| q_ovf | output | 1 | Sticky: push attempted while full |
| q_udf | output | 1 | Sticky: pop attempted while empty |

## Verification
Several properties are checked on every cycle. Each accepted read is followed by exactly one rd_valid, and no rd_valid appears without one. par_err never fires without rd_valid, and full and empty never hold together. The overflow and underflow flags set on rejected requests and then stay set, a rejected push at full leaves the level unchanged, and any mode change leaves the FIFO empty with both flags clear. The word values themselves are left to the bench's scenarios. These cover parity generation and the injected parity errors, old-data return on a same-address dual-port collision, strict FIFO ordering across a full 512-word fill and drain, and the sharing of storage between the FIFO and the random-access modes.

// File: rtl/mram_pkg.sv
package mram_pkg;

   typedef enum logic [1:0] {
      MODE_SP   = 2'd0,
      MODE_DP   = 2'd1,
      MODE_FIFO = 2'd2,
      MODE_OFF  = 2'd3
   } mram_mode_e;

endpackage

// File: rtl/mram_array.sv
module mram_array #(
   parameter int ADDR_W = 9,
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata,
   output logic              rvalid
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   // storage carries no reset; a read in the write cycle sees the old word
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= re;
         if (re) rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/mram_parity.sv
module mram_parity #(
   parameter int DATA_W    = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic            par_en,
   input  logic [DATA_W:0] wr_in,
   output logic [DATA_W:0] wr_out,
   input  logic [DATA_W:0] rd_in,
   output logic            rd_bad
);
   generate
      if (PARITY_EN) begin : g_par
         assign wr_out = par_en ? {^wr_in[DATA_W-1:0], wr_in[DATA_W-1:0]} : wr_in;
         assign rd_bad = rd_in[DATA_W] ^ (^rd_in[DATA_W-1:0]);
      end else begin : g_raw
         logic unused_raw;
         assign unused_raw = ^{par_en, rd_in};
         assign wr_out     = wr_in;
         assign rd_bad     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mram_fifo_ptr.sv
module mram_fifo_ptr #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push_req,
   input  logic              pop_req,
   output logic              push_ok,
   output logic              pop_ok,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              full,
   output logic              empty,
   output logic [ADDR_W:0]   level,
   output logic              ovf,
   output logic              udf
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] wp, rp;

   assign level   = wp - rp;
   assign empty   = (wp == rp);
   assign full    = (wp[ADDR_W] != rp[ADDR_W]) &&
                    (wp[ADDR_W-1:0] == rp[ADDR_W-1:0]);
   assign push_ok = push_req & ~full;
   assign pop_ok  = pop_req & ~empty;
   assign wr_addr = wp[ADDR_W-1:0];
   assign rd_addr = rp[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         ovf <= 1'b0;
         udf <= 1'b0;
      end else if (clear) begin
         wp  <= '0;
         rp  <= '0;
         ovf <= 1'b0;
         udf <= 1'b0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         if (push_req && full) ovf <= 1'b1;
         if (pop_req && empty) udf <= 1'b1;
      end
   end
endmodule

// File: rtl/mram_top.sv
module mram_top
   import mram_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_par_en,
   input  logic              p0_en,
   input  logic              p0_we,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [DATA_W:0]   p0_wdata,
   input  logic              p1_en,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic              q_push,
   input  logic              q_pop,
   output logic [DATA_W:0]   rd_data,
   output logic              rd_valid,
   output logic              par_err,
   output logic              q_full,
   output logic              q_empty,
   output logic [ADDR_W:0]   q_level,
   output logic              q_ovf,
   output logic              q_udf
);
   localparam int WORD_W = DATA_W + 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("mram_top: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mram_top: DATA_W must be positive");
      end
   endgenerate

   mram_mode_e mode_now, mode_q;
   logic       mode_chg, fifo_sel;

   assign mode_now = mram_mode_e'(cfg_mode);
   assign mode_chg = (mode_now != mode_q);
   assign fifo_sel = (mode_now == MODE_FIFO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_SP;
      else        mode_q <= mode_now;
   end

   // FIFO bookkeeping
   logic              push_ok, pop_ok;
   logic [ADDR_W-1:0] f_waddr, f_raddr;

   mram_fifo_ptr #(.ADDR_W(ADDR_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (mode_chg),
      .push_req (fifo_sel & q_push & ~mode_chg),
      .pop_req  (fifo_sel & q_pop & ~mode_chg),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .wr_addr  (f_waddr),
      .rd_addr  (f_raddr),
      .full     (q_full),
      .empty    (q_empty),
      .level    (q_level),
      .ovf      (q_ovf),
      .udf      (q_udf)
   );

   // per-mode routing onto the single storage array
   logic              a_we, a_re;
   logic [ADDR_W-1:0] a_waddr, a_raddr;

   always_comb begin
      a_we    = 1'b0;
      a_re    = 1'b0;
      a_waddr = p0_addr;
      a_raddr = p0_addr;
      unique case (mode_now)
         MODE_SP: begin
            a_we = p0_en & p0_we;
            a_re = p0_en & ~p0_we;
         end
         MODE_DP: begin
            a_we    = p0_en & p0_we;
            a_re    = p1_en;
            a_raddr = p1_addr;
         end
         MODE_FIFO: begin
            a_we    = push_ok;
            a_waddr = f_waddr;
            a_re    = pop_ok;
            a_raddr = f_raddr;
         end
         default: begin
            a_we = 1'b0;
            a_re = 1'b0;
         end
      endcase
   end

   logic [WORD_W-1:0] store_word;
   logic              rd_bad;

   mram_parity #(.DATA_W(DATA_W), .PARITY_EN(PARITY_EN)) u_par (
      .par_en (cfg_par_en),
      .wr_in  (p0_wdata),
      .wr_out (store_word),
      .rd_in  (rd_data),
      .rd_bad (rd_bad)
   );

   mram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (a_we),
      .waddr  (a_waddr),
      .wdata  (store_word),
      .re     (a_re),
      .raddr  (a_raddr),
      .rdata  (rd_data),
      .rvalid (rd_valid)
   );

   // parity checking follows the setting captured with the read request
   logic par_chk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    par_chk_q <= 1'b0;
      else if (a_re) par_chk_q <= cfg_par_en;
   end

   assign par_err = rd_valid & par_chk_q & rd_bad;
endmodule

// File: rtl/mram_chk.sv
module mram_chk
   import mram_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      cfg_mode,
   input logic [1:0]      mode_prev,
   input logic            p0_en,
   input logic            p0_we,
   input logic            p1_en,
   input logic            q_push,
   input logic            q_pop,
   input logic            rd_valid,
   input logic            par_err,
   input logic            q_full,
   input logic            q_empty,
   input logic [ADDR_W:0] q_level,
   input logic            q_ovf,
   input logic            q_udf
);
   localparam int DEPTH = 1 << ADDR_W;

   logic steady, in_fifo, rd_req;

   assign steady  = (cfg_mode == mode_prev);
   assign in_fifo = (cfg_mode == MODE_FIFO) && steady;
   assign rd_req  = ((cfg_mode == MODE_SP) && p0_en && !p0_we) ||
                    ((cfg_mode == MODE_DP) && p1_en) ||
                    (in_fifo && q_pop && !q_empty);

   p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   p_no_stray_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   p_par_err_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> rd_valid);

   p_full_empty_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty));

   p_level_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= (ADDR_W+1)'(DEPTH));

   p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fifo && q_push && q_full) |=> q_ovf);

   p_udf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fifo && q_pop && q_empty) |=> q_udf);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ovf && steady) |=> q_ovf);

   p_udf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_udf && steady) |=> q_udf);

   p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fifo && q_full && q_push && !q_pop) |=> (q_full && $stable(q_level)));

   p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !steady |=> (q_empty && !q_ovf && !q_udf && q_level == '0));

   p_off_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == MODE_OFF) |=> !rd_valid);
endmodule

bind mram_top mram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_mode  (cfg_mode),
   .mode_prev (mode_q),
   .p0_en     (p0_en),
   .p0_we     (p0_we),
   .p1_en     (p1_en),
   .q_push    (q_push),
   .q_pop     (q_pop),
   .rd_valid  (rd_valid),
   .par_err   (par_err),
   .q_full    (q_full),
   .q_empty   (q_empty),
   .q_level   (q_level),
   .q_ovf     (q_ovf),
   .q_udf     (q_udf)
);

// File: tb/tb_mram_top.sv
module tb_mram_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic       cfg_par_en = 1'b0;
   logic       p0_en = 1'b0, p0_we = 1'b0, p1_en = 1'b0, q_push = 1'b0, q_pop = 1'b0;
   logic [8:0] p0_addr = '0, p0_wdata = '0, p1_addr = '0;
   logic [8:0] rd_data;
   logic       rd_valid, par_err, q_full, q_empty, q_ovf, q_udf;
   logic [9:0] q_level;

   always #10 clk = ~clk;

   mram_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_par_en(cfg_par_en),
      .p0_en(p0_en), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
      .p1_en(p1_en), .p1_addr(p1_addr), .q_push(q_push), .q_pop(q_pop),
      .rd_data(rd_data), .rd_valid(rd_valid), .par_err(par_err),
      .q_full(q_full), .q_empty(q_empty), .q_level(q_level),
      .q_ovf(q_ovf), .q_udf(q_udf)
   );

   int nvec = 0;
   int nfail = 0;

   // bench model
   logic [8:0] ref_mem [512];
   logic [8:0] fq [$];
   int         fwp = 0;
   bit         m_ovf = 0, m_udf = 0;
   int         cur_mode = 0;

   // scoreboard
   logic [8:0] sb_data [$];
   bit         sb_err [$];
   string      sb_tag [$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FIFO_BENCH FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [8:0] stored(input logic [8:0] d, input bit pe);
      return pe ? {^d[7:0], d[7:0]} : d;
   endfunction

   function automatic bit bad(input logic [8:0] w);
      return w[8] ^ (^w[7:0]);
   endfunction

   task automatic expect_read(input logic [8:0] w, input string tag);
      sb_data.push_back(w);
      sb_err.push_back(cfg_par_en && bad(w));
      sb_tag.push_back(tag);
   endtask

   // monitor: compares each returned word against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_data.size() == 0) begin
            chk("R4 unexpected rd_valid", 32'd1, 32'd0);
         end else begin
            logic [8:0] w;
            bit         e;
            string      t;
            w = sb_data.pop_front();
            e = sb_err.pop_front();
            t = sb_tag.pop_front();
            chk({t, " R4 data"}, 32'(rd_data), 32'(w));
            chk({t, " R7 par_err"}, 32'(par_err), 32'(e));
         end
      end else if (rst_n) begin
         chk("R7 par_err idle", 32'(par_err), 32'd0);
      end
   end

   task automatic check_flags(input string tag);
      chk({tag, " level"}, 32'(q_level), 32'(fq.size()));
      chk({tag, " empty"}, 32'(q_empty), 32'(fq.size() == 0));
      chk({tag, " full"},  32'(q_full),  32'(fq.size() == 512));
      chk({tag, " ovf"},   32'(q_ovf),   32'(m_ovf));
      chk({tag, " udf"},   32'(q_udf),   32'(m_udf));
   endtask

   task automatic idle_inputs();
      p0_en = 0; p0_we = 0; p1_en = 0; q_push = 0; q_pop = 0;
   endtask

   task automatic step(input bit e0, input bit w0, input int a0, input int d0,
                       input bit e1, input int a1, input bit ps, input bit pp,
                       input string tag);
      @(negedge clk);
      p0_en = e0; p0_we = w0; p0_addr = 9'(a0); p0_wdata = 9'(d0);
      p1_en = e1; p1_addr = 9'(a1); q_push = ps; q_pop = pp;
      case (cur_mode)
         0: begin
            if (e0 && w0) ref_mem[a0] = stored(9'(d0), cfg_par_en);
            else if (e0) expect_read(ref_mem[a0], tag);
         end
         1: begin
            if (e1) expect_read(ref_mem[a1], tag);
            if (e0 && w0) ref_mem[a0] = stored(9'(d0), cfg_par_en);
         end
         2: begin
            bit full_n, empty_n;
            full_n  = (fq.size() == 512);
            empty_n = (fq.size() == 0);
            if (pp && !empty_n) expect_read(fq.pop_front(), tag);
            if (pp && empty_n) m_udf = 1;
            if (ps && !full_n) begin
               fq.push_back(stored(9'(d0), cfg_par_en));
               ref_mem[fwp % 512] = stored(9'(d0), cfg_par_en);
               fwp++;
            end
            if (ps && full_n) m_ovf = 1;
         end
         default: ;
      endcase
      @(negedge clk);
      idle_inputs();
      check_flags(tag);
   endtask

   task automatic set_mode(input int m, input bit ps, input bit pp, input string tag);
      @(negedge clk);
      cfg_mode = 2'(m); q_push = ps; q_pop = pp; p0_wdata = 9'h0AA;
      if (m != cur_mode) begin
         fq.delete(); fwp = 0; m_ovf = 0; m_udf = 0;
      end
      cur_mode = m;
      @(negedge clk);
      idle_inputs();
      check_flags(tag);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      nvec++; nfail++;
      $display("FIFO_BENCH FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 512; i++) ref_mem[i] = 'x;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rd_valid", 32'(rd_valid), 0);
      chk("R1 par_err", 32'(par_err), 0);
      check_flags("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_flags("R1 after release");
      chk("R1 rd_valid after release", 32'(rd_valid), 0);

      // single-port, parity off: R2, R6
      step(1, 1, 0,   9'h1A5, 0, 0, 0, 0, "R2 wr0");
      step(1, 1, 511, 9'h0FF, 0, 0, 0, 0, "R2 wr511");
      step(1, 1, 5,   9'h155, 0, 0, 0, 0, "R6 wr5");
      step(0, 1, 5,   9'h000, 0, 0, 0, 0, "R2 disabled write");
      step(1, 0, 0,   0, 0, 0, 0, 0, "R6 rd0");
      step(1, 0, 511, 0, 0, 0, 0, 0, "R2 rd511");
      step(1, 0, 5,   0, 0, 0, 0, 0, "R2 rd5 after disabled write");
      // R11: FIFO requests ignored in single-port mode
      step(0, 0, 0,   9'h033, 0, 0, 1, 0, "R11 push in SP");
      step(0, 0, 0,   0, 0, 0, 0, 1, "R11 pop in SP");

      // parity on: R5, R7
      cfg_par_en = 1'b1;
      step(1, 1, 10, 9'h103, 0, 0, 0, 0, "R5 wr10");
      step(1, 1, 11, 9'h007, 0, 0, 0, 0, "R5 wr11");
      step(1, 0, 10, 0, 0, 0, 0, 0, "R5 rd10");
      step(1, 0, 11, 0, 0, 0, 0, 0, "R5 rd11");
      cfg_par_en = 1'b0;
      step(1, 1, 12, 9'h001, 0, 0, 0, 0, "R7 wr bad word");
      step(1, 0, 12, 0, 0, 0, 0, 0, "R7 rd bad unchecked");
      cfg_par_en = 1'b1;
      step(1, 0, 12, 0, 0, 0, 0, 0, "R7 rd bad checked");
      step(1, 0, 0,  0, 0, 0, 0, 0, "R7 rd0 checked");
      cfg_par_en = 1'b0;

      // dual port: R3
      set_mode(1, 0, 0, "R10 to DP");
      step(1, 1, 20, 9'h0C3, 1, 0, 0, 0, "R3 wr20 rd0");
      step(1, 1, 20, 9'h13C, 1, 20, 0, 0, "R3 same-addr old data");
      step(0, 0, 0,  0, 1, 20, 0, 0, "R3 rd20 new data");
      step(0, 0, 0,  9'h011, 0, 0, 1, 0, "R11 push in DP");

      // reserved mode: R11
      set_mode(3, 0, 0, "R10 to OFF");
      step(1, 1, 20, 9'h000, 1, 20, 0, 0, "R11 off write");
      step(1, 0, 20, 0, 0, 0, 0, 0, "R11 off read");
      set_mode(0, 0, 0, "R10 to SP");
      step(1, 0, 20, 0, 0, 0, 0, 0, "R11 rd20 after off");

      // FIFO: R8, R9, R10
      set_mode(2, 1, 0, "R10 push on change ignored");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R9 pop empty");
      step(0, 0, 0, 9'h101, 0, 0, 1, 0, "R8 push a");
      cfg_par_en = 1'b1;
      step(0, 0, 0, 9'h0F1, 0, 0, 1, 0, "R8 push b");
      step(0, 0, 0, 9'h022, 0, 0, 1, 1, "R8 push c pop a");
      step(1, 1, 300, 9'h1FF, 0, 0, 0, 0, "R11 p0 write in FIFO");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R8 pop b");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R8 pop c");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R9 pop empty again");
      cfg_par_en = 1'b0;
      set_mode(0, 0, 0, "R10 FIFO to SP clears");
      step(1, 0, 1, 0, 0, 0, 0, 0, "R8 shared storage addr1");

      set_mode(2, 0, 0, "R10 to FIFO");
      for (int i = 0; i < 512; i++)
         step(0, 0, 0, (i * 37 + 5) & 9'h1FF, 0, 0, 1, 0, "R8 fill");
      step(0, 0, 0, 9'h055, 0, 0, 1, 0, "R9 push full");
      step(0, 0, 0, 9'h066, 0, 0, 1, 1, "R9 push full with pop");
      step(0, 0, 0, 9'h077, 0, 0, 1, 0, "R8 push after pop");
      for (int i = 0; i < 512; i++)
         step(0, 0, 0, 0, 0, 0, 0, 1, "R8 drain");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R9 pop drained");
      set_mode(0, 0, 0, "R10 clear flags");
      step(1, 0, 300, 0, 0, 0, 0, 0, "R11 addr300 holds FIFO word");

      repeat (3) @(negedge clk);
      chk("R4 outstanding reads", 32'(sb_data.size()), 0);
      finish_run();
   end
endmodule